// File: doc/BRIEF.md
# Epoch-Sequenced Control Point Driver

This block drives inserted control points during a logic self-test run. A run is split into four test epochs, numbered 0 to 3 and visited in that order. A fixed, parameterised number of patterns is applied in each epoch, and the pattern-clock enable marks each pattern. A decoder turns the current epoch into per-point select lines. Each control point is either a 0-injection gate, built from an AND, or a 1-injection gate, built from an OR. A point overrides its functional signal only while test mode is high and its select is active. In every other case it passes the functional value straight through.

Two points are provided. Point `c1` pulls signal `g` low during epochs 1 and 2. Point `c2` pulls signal `h` high during epochs 2 and 3. A pulse on `start` begins a run. After the last pattern of epoch 3, `done` rises and the counters freeze until the next `start`.

Top module: `epoch_tp_activator`

## Requirements
- R1: After reset, `epoch` is 0, `done` is 0, no run is active, and `c1 = g` and `c2 = h`.
- R2: A `start` pulse sets `epoch` to 0, clears `done` and the pattern count, and begins a run from the next clock edge.
- R3: The pattern count advances only on clock edges where `pat_en` is 1 and a run is active. A cycle with `pat_en` at 0 leaves `epoch` and `done` unchanged.
- R4: `epoch` advances by one only on the edge that completes the PATS_PER_EPOCH-th pattern of the epoch. The order is 0, 1, 2, 3, and `epoch` is a 2-bit binary number.
- R5: While test mode is 1 and a run is active in epoch 1 or 2, `c1` is 0. In epochs 0 and 3, `c1` equals `g`.
- R6: While test mode is 1 and a run is active in epoch 2 or 3, `c2` is 1. In epochs 0 and 1, `c2` equals `h`.
- R7: While test mode is 0, `c1 = g` and `c2 = h` in every epoch, whatever the counters hold.
- R8: The edge that completes the last pattern of epoch 3 sets `done` and ends the run. `epoch` then stays at 3, `done` stays high, and both points are transparent until the next `start`.
- R9: A `start` that arrives during a run discards the run in progress and restarts it at epoch 0 with a cleared count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Allows the control points to override their signals |
| start | input | 1 | Single-cycle pulse that begins or restarts a run |
| pat_en | input | 1 | One pulse per applied test pattern |
| g | input | 1 | Functional signal feeding the 0-injection point |
| h | input | 1 | Functional signal feeding the 1-injection point |
| c1 | output | 1 | Controlled version of g |
| c2 | output | 1 | Controlled version of h |
| epoch | output | 2 | Current epoch number |
| done | output | 1 | High once all four epochs have completed |

## Verification
The hardest condition to reach from the ports is the epoch boundary itself. The boundary cycle happens only when the pattern count sits at its last value and `pat_en` is high in the same cycle. Gaps in `pat_en` move that cycle around in time. The bench therefore drives `pat_en` randomly at about 70 percent, with random `g` and `h`, and tracks the expected count in its own model. Every boundary, including the one that raises `done`, is then hit with an unpredictable gap pattern around it. Directed parts of the bench restart a run in the middle of an epoch, repeat a full run with test mode low, and clock through several cycles after `done`.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

    localparam int EPOCH_W    = 2;
    localparam int NUM_EPOCHS = 1 << EPOCH_W;

    typedef enum logic [EPOCH_W-1:0] {
        EP_0 = 2'd0,
        EP_1 = 2'd1,
        EP_2 = 2'd2,
        EP_3 = 2'd3
    } epoch_e;

endpackage

// File: rtl/tpa_sequencer.sv
module tpa_sequencer
    import tpa_pkg::*;
#(
    parameter int PATS_PER_EPOCH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   pat_en,
    output logic   running,
    output epoch_e epoch,
    output logic   done
);

    localparam int CNT_W = (PATS_PER_EPOCH > 1) ? $clog2(PATS_PER_EPOCH) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PATS_PER_EPOCH - 1);

    typedef struct packed {
        logic             run;
        epoch_e           ep;
        logic [CNT_W-1:0] cnt;
        logic             fin;
    } seq_t;

    seq_t s_d, s_q;
    logic last_pat;

    always_comb begin
        s_d      = s_q;
        last_pat = (s_q.cnt == CNT_LAST);
        if (start) begin
            s_d.run = 1'b1;
            s_d.ep  = EP_0;
            s_d.cnt = '0;
            s_d.fin = 1'b0;
        end else if (s_q.run && pat_en) begin
            if (last_pat) begin
                s_d.cnt = '0;
                if (s_q.ep == EP_3) begin
                    s_d.run = 1'b0;
                    s_d.fin = 1'b1;
                end else begin
                    s_d.ep = epoch_e'(s_q.ep + 2'd1);
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{run: 1'b0, ep: EP_0, cnt: '0, fin: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign running = s_q.run;
    assign epoch   = s_q.ep;
    assign done    = s_q.fin;

    // R2: start always clears the epoch and done
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (epoch == EP_0) && !done && running);

    // R3: without a pattern pulse nothing advances
    p_hold_without_pat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !pat_en) |=> $stable(epoch) && $stable(done));

    // R4: epoch only holds or steps by one
    p_epoch_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (epoch == $past(epoch)) || (epoch == epoch_e'($past(epoch) + 2'd1)));

    // R8: done is sticky at epoch 3 until restart
    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && (epoch == EP_3) && !running);

endmodule

// File: rtl/tpa_phase_decoder.sv
module tpa_phase_decoder
    import tpa_pkg::*;
#(
    parameter int                         N_POINTS    = 2,
    parameter logic [N_POINTS*NUM_EPOCHS-1:0] EPOCH_MASKS = '0
) (
    input  logic                running,
    input  epoch_e              epoch,
    output logic [N_POINTS-1:0] sel
);

    for (genvar i = 0; i < N_POINTS; i++) begin : g_sel
        localparam logic [NUM_EPOCHS-1:0] MASK = EPOCH_MASKS[i*NUM_EPOCHS +: NUM_EPOCHS];
        assign sel[i] = running & MASK[epoch];
    end

endmodule

// File: rtl/tpa_ctrl_point.sv
module tpa_ctrl_point #(
    parameter bit FORCE_ONE = 1'b0
) (
    input  logic test_mode,
    input  logic sel,
    input  logic din,
    output logic dout
);

    logic inject;
    assign inject = test_mode & sel;

    if (FORCE_ONE) begin : g_or_point
        assign dout = din | inject;
    end else begin : g_and_point
        assign dout = din & ~inject;
    end

endmodule

// File: rtl/epoch_tp_activator.sv
module epoch_tp_activator
    import tpa_pkg::*;
#(
    parameter int                    PATS_PER_EPOCH = 16,
    parameter logic [NUM_EPOCHS-1:0] C1_EPOCHS      = 4'b0110,
    parameter logic [NUM_EPOCHS-1:0] C2_EPOCHS      = 4'b1100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_mode,
    input  logic               start,
    input  logic               pat_en,
    input  logic               g,
    input  logic               h,
    output logic               c1,
    output logic               c2,
    output logic [EPOCH_W-1:0] epoch,
    output logic               done
);

    localparam int N_POINTS = 2;

    logic                running;
    epoch_e              ep;
    logic [N_POINTS-1:0] sel;

    tpa_sequencer #(
        .PATS_PER_EPOCH(PATS_PER_EPOCH)
    ) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .pat_en (pat_en),
        .running(running),
        .epoch  (ep),
        .done   (done)
    );

    tpa_phase_decoder #(
        .N_POINTS   (N_POINTS),
        .EPOCH_MASKS({C2_EPOCHS, C1_EPOCHS})
    ) i_dec (
        .running(running),
        .epoch  (ep),
        .sel    (sel)
    );

    tpa_ctrl_point #(.FORCE_ONE(1'b0)) i_cp_zero (
        .test_mode(test_mode),
        .sel      (sel[0]),
        .din      (g),
        .dout     (c1)
    );

    tpa_ctrl_point #(.FORCE_ONE(1'b1)) i_cp_one (
        .test_mode(test_mode),
        .sel      (sel[1]),
        .din      (h),
        .dout     (c2)
    );

    assign epoch = ep;

    // R7: test mode low makes every point transparent
    p_transparent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (c1 == g) && (c2 == h));

    // R5: c1 pulled low in epochs 1 and 2
    p_c1_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && running && (ep == EP_1 || ep == EP_2)) |-> !c1);

    // R6: c2 pulled high in epochs 2 and 3
    p_c2_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && running && (ep == EP_2 || ep == EP_3)) |-> c2);

    // R8: once finished, both points pass through
    p_idle_transparent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c1 == g) && (c2 == h));

endmodule

// File: tb/test_epoch_tp_activator.sv
module test_epoch_tp_activator;

    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0;
    logic       start = 1'b0;
    logic       pat_en = 1'b0;
    logic       g = 1'b0;
    logic       h = 1'b0;
    logic       c1, c2, done;
    logic [1:0] epoch;

    int checks = 0;
    int errors = 0;

    bit m_run, m_done;
    int m_ep, m_cnt;
    bit prev_start, prev_en, prev_run;

    always #10 clk = ~clk;

    epoch_tp_activator #(.PATS_PER_EPOCH(P)) i_epoch_tp_activator (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .pat_en(pat_en), .g(g), .h(h), .c1(c1), .c2(c2),
        .epoch(epoch), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_c1(bit tm, bit run, int ep, bit gi);
        return (tm && run && (ep == 1 || ep == 2)) ? 1'b0 : gi;
    endfunction

    function automatic bit exp_c2(bit tm, bit run, int ep, bit hi);
        return (tm && run && (ep == 2 || ep == 3)) ? 1'b1 : hi;
    endfunction

    task automatic cycle(input bit st, input bit en, input bit tm);
        string ep_tag;
        @(negedge clk);
        start = st; pat_en = en; test_mode = tm;
        g = 1'($urandom); h = 1'($urandom);
        #1;
        if (prev_start) ep_tag = prev_run ? "R9" : "R2";
        else if (prev_en) ep_tag = "R4";
        else ep_tag = "R3";
        check(ep_tag, int'(epoch), m_ep);
        check(m_done ? "R8" : ep_tag, int'(done), int'(m_done));
        check(tm ? (m_done ? "R8" : "R5") : "R7", int'(c1), int'(exp_c1(tm, m_run, m_ep, g)));
        check(tm ? (m_done ? "R8" : "R6") : "R7", int'(c2), int'(exp_c2(tm, m_run, m_ep, h)));
        prev_start = st; prev_en = en; prev_run = m_run;
        if (st) begin
            m_run = 1'b1; m_ep = 0; m_cnt = 0; m_done = 1'b0;
        end else if (m_run && en) begin
            if (m_cnt == P - 1) begin
                m_cnt = 0;
                if (m_ep == 3) begin m_run = 1'b0; m_done = 1'b1; end
                else m_ep++;
            end else m_cnt++;
        end
    endtask

    task automatic full_run(input bit tm);
        cycle(1'b1, 1'b0, tm);
        for (int n = 0; n < 400 && !m_done; n++)
            cycle(1'b0, ($urandom % 10) < 7, tm);
        for (int n = 0; n < 4; n++) cycle(1'b0, 1'b1, tm);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_run = 0; m_done = 0; m_ep = 0; m_cnt = 0;
        prev_start = 0; prev_en = 0; prev_run = 0;
        g = 1'b1; h = 1'b0; test_mode = 1'b1;
        #35;
        // R1: reset values
        check("R1", int'(epoch), 0);
        check("R1", int'(done), 0);
        check("R1", int'(c1), 1);
        check("R1", int'(c2), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 3; n++) cycle(1'b0, 1'b1, 1'b1);
        // R5 R6 R4 R8: full run with test mode high
        full_run(1'b1);
        // R7: full run with test mode low
        full_run(1'b0);
        // R9: restart in the middle of epoch 2
        cycle(1'b1, 1'b0, 1'b1);
        for (int n = 0; n < 2 * P + 2; n++) cycle(1'b0, 1'b1, 1'b1);
        cycle(1'b1, 1'b1, 1'b1);
        // R3: pattern enable held low mid-epoch
        for (int n = 0; n < 8; n++) cycle(1'b0, 1'b0, 1'b1);
        for (int n = 0; n < 400 && !m_done; n++)
            cycle(1'b0, ($urandom % 10) < 7, 1'b1);
        for (int n = 0; n < 3; n++) cycle(1'b0, 1'b1, 1'b1);
        // mixed test mode during a run
        cycle(1'b1, 1'b0, 1'b1);
        for (int n = 0; n < 400 && !m_done; n++)
            cycle(1'b0, ($urandom % 10) < 7, 1'($urandom));
        summary();
    end

endmodule